// File: doc/BRIEF.md
# Adaptive Dead-Time Gate Sequencer

This block turns one pulse-width request into two mutually exclusive gate enables for a synchronous step-down power stage. One enable is for the high-side switch and one is for the low-side switch. The block does not wait a fixed dead time between the two switches. It waits for sensed evidence that the outgoing switch has actually turned off. The low side is enabled once the switch node has been seen low after the high side is released. The high side is enabled once the low-side gate has been seen to have fallen after the low side is released.

When inductor current is negative, the switch node may never fall after high-side release. A watchdog then turns the low side on after a set number of cycles so that the current can recirculate. A free-running period counter closes a duty window for the last part of every switching period, which limits the high-side on-time to 80 % of the period.

Protection logic can force both gates off at once, or force the low side on. A start-up flag can hold the low side off over a pre-biased output, and a protection request to force the low side on overrides that flag. The comparator outputs reach the block as synchronous digital inputs.

Top module: `buck_gate_sequencer`

## Requirements
- R1: While reset is asserted, and after reset is released, both enables are low. They stay low, whatever the feedback inputs do, until the first cycle in which `pwm_req` is high after being low in the previous cycle.
- R2: After the high-side enable falls, both enables are low for at least one cycle. The low-side enable rises in the cycle after the first dead cycle in which `sw_low` is sampled high.
- R3: After the low-side enable falls on a request, both enables are low for at least one cycle. The high-side enable rises only in the cycle after a dead cycle in which `ls_gate_low` is sampled high, and it stays low while `ls_gate_low` stays low.
- R4: If `sw_low` stays low after high-side release, the low side turns on anyway once exactly WDOG_CYCLES dead cycles have passed (default 8).
- R5: A phase counter runs from 0 in the first cycle after reset release and wraps after PERIOD_CYCLES cycles (default 20). While the phase is at or above PERIOD_CYCLES*80/100 (default 16), the request is treated as low and `hs_en` is low. When the window reopens with the request still high, the stage goes back to the high side through the R3 handshake.
- R6: While `ls_inhibit` is high, `ls_en` is low in the same cycle. If `force_ls_on` is also high, `ls_en` follows the sequencer state regardless of the inhibit.
- R7: `force_ls_on` takes priority over the request. The high-side enable drops in the next cycle, the low side then turns on through the R2 handshake, and the low side is held on for as long as the force is present.
- R8: `force_off` drives both enables low in the same cycle. After it is released, both stay low until a new rising edge of `pwm_req`.
- R9: `hs_en` and `ls_en` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwm_req | input | 1 | Pulse-width request; high asks for high-side conduction |
| sw_low | input | 1 | Switch node sensed low |
| ls_gate_low | input | 1 | Low-side gate voltage sensed fallen |
| force_ls_on | input | 1 | Protection request to turn the low side on |
| force_off | input | 1 | Protection request to turn both gates off |
| ls_inhibit | input | 1 | Pre-bias start-up flag that holds the low side off |
| hs_en | output | 1 | High-side gate enable |
| ls_en | output | 1 | Low-side gate enable |

## Verification
On every cycle, the bound assertions check the following: the two enables are never high together, a forced shutdown leaves both low, the high side never conducts in the closed part of the period, and each enable rises only after the opposite enable was low and, for the high side, only after the low-side gate was seen fallen. The bench scenarios are needed for the timing that depends on history. These are the exact dead-time lengths under prompt and late feedback, the watchdog expiry count, the wait for a fresh request edge after reset and after a forced shutdown, and the priority order among the inhibit, the force-on and the request.

// File: rtl/gate_seq_pkg.sv
package gate_seq_pkg;

  typedef enum logic [2:0] {
    SEQ_ALL_OFF = 3'd0,
    SEQ_HS_ON   = 3'd1,
    SEQ_DEAD_HL = 3'd2,
    SEQ_LS_ON   = 3'd3,
    SEQ_DEAD_LH = 3'd4
  } seq_state_e;

endpackage

// File: rtl/duty_window.sv
module duty_window #(
  parameter int PERIOD_CYCLES = 20,
  parameter int MAX_DUTY_PCT  = 80
) (
  input  logic clk,
  input  logic rst_n,
  output logic win_open
);
  localparam int PW     = (PERIOD_CYCLES > 2) ? $clog2(PERIOD_CYCLES) : 1;
  localparam int MAX_ON = (PERIOD_CYCLES * MAX_DUTY_PCT) / 100;
  localparam logic [PW-1:0] LAST_PH  = PW'(PERIOD_CYCLES - 1);
  localparam logic [PW-1:0] ON_LIMIT = PW'(MAX_ON);

  logic [PW-1:0] phase_q, phase_d;

  always_comb begin
    if (phase_q == LAST_PH) phase_d = '0;
    else                    phase_d = phase_q + PW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase_q <= '0;
    else        phase_q <= phase_d;
  end

  assign win_open = (phase_q < ON_LIMIT);

endmodule

// File: rtl/release_watchdog.sv
module release_watchdog #(
  parameter int WDOG_CYCLES = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic armed,
  output logic expired
);
  localparam int CW = $clog2(WDOG_CYCLES + 1);
  localparam logic [CW-1:0] LAST_CNT = CW'(WDOG_CYCLES - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  assign cnt_en = armed && (cnt_q != LAST_CNT);

  always_comb begin
    if (!armed)      cnt_d = '0;
    else if (cnt_en) cnt_d = cnt_q + CW'(1);
    else             cnt_d = cnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign expired = armed && (cnt_q == LAST_CNT);

endmodule

// File: rtl/gate_handshake_fsm.sv
module gate_handshake_fsm
  import gate_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pwm_req,
  input  logic       win_open,
  input  logic       sw_low,
  input  logic       ls_gate_low,
  input  logic       wd_expired,
  input  logic       force_ls_on,
  input  logic       force_off,
  output seq_state_e state
);
  seq_state_e state_q, state_d;
  logic       req_prev_q;
  logic       req_ok;
  logic       req_rise;

  assign req_ok   = pwm_req && win_open;
  assign req_rise = req_ok && !req_prev_q;

  always_comb begin
    state_d = state_q;
    if (force_off) begin
      state_d = SEQ_ALL_OFF;
    end else begin
      case (state_q)
        SEQ_ALL_OFF: begin
          if (force_ls_on)   state_d = SEQ_DEAD_HL;
          else if (req_rise) state_d = SEQ_DEAD_LH;
        end
        SEQ_HS_ON: begin
          if (force_ls_on || !req_ok) state_d = SEQ_DEAD_HL;
        end
        SEQ_DEAD_HL: begin
          if (sw_low || wd_expired) state_d = SEQ_LS_ON;
        end
        SEQ_LS_ON: begin
          if (!force_ls_on && req_ok) state_d = SEQ_DEAD_LH;
        end
        SEQ_DEAD_LH: begin
          if (force_ls_on || !req_ok) state_d = SEQ_LS_ON;
          else if (ls_gate_low)       state_d = SEQ_HS_ON;
        end
        default: state_d = SEQ_ALL_OFF;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= SEQ_ALL_OFF;
      req_prev_q <= 1'b0;
    end else begin
      state_q    <= state_d;
      req_prev_q <= pwm_req;
    end
  end

  assign state = state_q;

endmodule

// File: rtl/buck_gate_sequencer.sv
module buck_gate_sequencer
  import gate_seq_pkg::*;
#(
  parameter int PERIOD_CYCLES = 20,
  parameter int MAX_DUTY_PCT  = 80,
  parameter int WDOG_CYCLES   = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pwm_req,
  input  logic sw_low,
  input  logic ls_gate_low,
  input  logic force_ls_on,
  input  logic force_off,
  input  logic ls_inhibit,
  output logic hs_en,
  output logic ls_en
);
  seq_state_e state;
  logic       win_open;
  logic       wd_expired;
  logic       wd_armed;

  duty_window #(
    .PERIOD_CYCLES (PERIOD_CYCLES),
    .MAX_DUTY_PCT  (MAX_DUTY_PCT)
  ) u_window (
    .clk      (clk),
    .rst_n    (rst_n),
    .win_open (win_open)
  );

  assign wd_armed = (state == SEQ_DEAD_HL);

  release_watchdog #(
    .WDOG_CYCLES (WDOG_CYCLES)
  ) u_wdog (
    .clk     (clk),
    .rst_n   (rst_n),
    .armed   (wd_armed),
    .expired (wd_expired)
  );

  gate_handshake_fsm u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .pwm_req     (pwm_req),
    .win_open    (win_open),
    .sw_low      (sw_low),
    .ls_gate_low (ls_gate_low),
    .wd_expired  (wd_expired),
    .force_ls_on (force_ls_on),
    .force_off   (force_off),
    .state       (state)
  );

  // Output gating: shutdown and the closed duty window act in the same cycle.
  assign hs_en = (state == SEQ_HS_ON) && win_open && !force_off;
  assign ls_en = (state == SEQ_LS_ON) && !force_off && (!ls_inhibit || force_ls_on);

endmodule

// File: rtl/gate_seq_checker.sv
module gate_seq_checker #(
  parameter int PERIOD_CYCLES = 20,
  parameter int MAX_DUTY_PCT  = 80
) (
  input logic clk,
  input logic rst_n,
  input logic force_off,
  input logic ls_gate_low,
  input logic hs_en,
  input logic ls_en
);
  localparam int CHK_ON = (PERIOD_CYCLES * MAX_DUTY_PCT) / 100;

  int chk_phase;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                              chk_phase <= 0;
    else if (chk_phase >= PERIOD_CYCLES - 1) chk_phase <= 0;
    else                                     chk_phase <= chk_phase + 1;
  end

  assert_never_both_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(hs_en && ls_en));

  assert_shutdown_R8: assert property (@(posedge clk) disable iff (!rst_n)
    force_off |-> (!hs_en && !ls_en));

  assert_duty_window_R5: assert property (@(posedge clk) disable iff (!rst_n)
    hs_en |-> (chk_phase < CHK_ON));

  assert_hs_after_ls_fall_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hs_en) |-> ($past(ls_gate_low) && !$past(ls_en)));

  assert_ls_after_hs_off_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ls_en) |-> !$past(hs_en));

endmodule

bind buck_gate_sequencer gate_seq_checker #(
  .PERIOD_CYCLES (PERIOD_CYCLES),
  .MAX_DUTY_PCT  (MAX_DUTY_PCT)
) u_gate_seq_checker (
  .clk         (clk),
  .rst_n       (rst_n),
  .force_off   (force_off),
  .ls_gate_low (ls_gate_low),
  .hs_en       (hs_en),
  .ls_en       (ls_en)
);

// File: tb/test_buck_gate_sequencer.sv
`timescale 1ns/1ps
module test_buck_gate_sequencer;
  localparam int P  = 20;
  localparam int W  = 8;

  typedef struct {
    int    cyc;
    logic  hs;
    logic  ls;
    string tag;
  } exp_t;

  logic clk = 1'b0;
  logic rst_n;
  logic pwm_req, sw_low, ls_gate_low, force_ls_on, force_off, ls_inhibit;
  logic hs_en, ls_en;

  int   cyc;
  int   n_tests = 0;
  int   n_fail  = 0;
  exp_t q[$];

  always #2 clk = ~clk;

  buck_gate_sequencer i_buck_gate_sequencer (
    .clk         (clk),
    .rst_n       (rst_n),
    .pwm_req     (pwm_req),
    .sw_low      (sw_low),
    .ls_gate_low (ls_gate_low),
    .force_ls_on (force_ls_on),
    .force_off   (force_off),
    .ls_inhibit  (ls_inhibit),
    .hs_en       (hs_en),
    .ls_en       (ls_en)
  );

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) cyc <= 0;
    else        cyc <= cyc + 1;
  end

  task automatic compare(input logic eh, input logic el, input string tag);
    n_tests++;
    if (hs_en !== eh || ls_en !== el) begin
      n_fail++;
      $display("FAIL %s cycle %0d: hs_en=%0b ls_en=%0b expected hs_en=%0b ls_en=%0b",
               tag, cyc, hs_en, ls_en, eh, el);
    end
  endtask

  // Monitor: pop expectations scheduled for the current cycle.
  always @(negedge clk) begin
    if (rst_n) begin
      while (q.size() > 0 && q[0].cyc <= cyc) begin
        if (q[0].cyc < cyc) begin
          n_tests++;
          n_fail++;
          $display("FAIL %s: expectation for cycle %0d missed, now %0d, expected hs=%0b ls=%0b",
                   q[0].tag, q[0].cyc, cyc, q[0].hs, q[0].ls);
        end else begin
          compare(q[0].hs, q[0].ls, q[0].tag);
        end
        void'(q.pop_front());
      end
    end
  end

  task automatic expect_at(input int c, input logic h, input logic l, input string tag);
    exp_t e;
    e.cyc = c; e.hs = h; e.ls = l; e.tag = tag;
    q.push_back(e);
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic run_to(input int c);
    while (cyc < c) tick();
  endtask

  task automatic wait_phase0();
    tick();
    while ((cyc % P) != 0) tick();
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: run did not finish, actual=hung expected=done");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    int b;
    rst_n = 1'b0;
    pwm_req = 0; sw_low = 0; ls_gate_low = 0;
    force_ls_on = 0; force_off = 0; ls_inhibit = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    compare(1'b0, 1'b0, "R1 reset");
    rst_n = 1'b1;

    // R1: feedback activity without a request edge keeps both off
    tick();
    sw_low = 1; ls_gate_low = 1;
    expect_at(3, 0, 0, "R1");
    expect_at(6, 0, 0, "R1");
    sw_low = 0;

    // Normal cycle, slow gate feedback, duty window (R2, R3, R5)
    wait_phase0();
    b = cyc;
    expect_at(b+1, 0, 0, "R3");
    expect_at(b+2, 1, 0, "R3");
    expect_at(b+5, 1, 0, "R2");
    expect_at(b+6, 0, 0, "R2");
    expect_at(b+7, 0, 1, "R2");
    expect_at(b+10, 0, 0, "R3");
    expect_at(b+11, 0, 0, "R3");
    expect_at(b+12, 1, 0, "R3");
    expect_at(b+15, 1, 0, "R5");
    expect_at(b+16, 0, 0, "R5");
    expect_at(b+18, 0, 1, "R5");
    expect_at(b+22, 1, 0, "R5");
    expect_at(b+25, 0, 1, "R2");
    pwm_req = 1; ls_gate_low = 1;
    run_to(b+5);  pwm_req = 0; sw_low = 1;
    run_to(b+9);  pwm_req = 1; ls_gate_low = 0;
    run_to(b+11); ls_gate_low = 1;
    run_to(b+23); pwm_req = 0;
    run_to(b+26);

    // Watchdog: switch node never falls (R4)
    wait_phase0();
    b = cyc;
    expect_at(b+2, 1, 0, "R4");
    expect_at(b+4, 0, 0, "R4");
    expect_at(b+11, 0, 0, "R4");
    expect_at(b+12, 0, 1, "R4");
    pwm_req = 1; ls_gate_low = 1; sw_low = 0;
    run_to(b+3); pwm_req = 0;
    run_to(b+13);

    // Pre-bias inhibit and its override (R6)
    b = cyc;
    expect_at(b+1, 0, 0, "R6");
    expect_at(b+3, 0, 1, "R6");
    expect_at(b+5, 0, 0, "R6");
    expect_at(b+7, 0, 1, "R6");
    run_to(b+1); ls_inhibit = 1;
    run_to(b+3); force_ls_on = 1;
    run_to(b+5); force_ls_on = 0;
    run_to(b+7); ls_inhibit = 0;
    run_to(b+8);

    // Force low side on while high side conducts (R7)
    wait_phase0();
    b = cyc;
    expect_at(b+2, 1, 0, "R7");
    expect_at(b+4, 1, 0, "R7");
    expect_at(b+5, 0, 0, "R7");
    expect_at(b+6, 0, 1, "R7");
    expect_at(b+8, 0, 1, "R7");
    expect_at(b+11, 1, 0, "R7");
    pwm_req = 1; ls_gate_low = 1; sw_low = 0;
    run_to(b+4);  force_ls_on = 1; sw_low = 1;
    run_to(b+9);  force_ls_on = 0;
    run_to(b+12); pwm_req = 0;
    run_to(b+15);

    // Forced shutdown, then wait for a new request edge (R8)
    wait_phase0();
    b = cyc;
    expect_at(b+2, 1, 0, "R8");
    expect_at(b+4, 0, 0, "R8");
    expect_at(b+5, 0, 0, "R8");
    expect_at(b+8, 0, 0, "R8");
    expect_at(b+10, 0, 0, "R8");
    expect_at(b+14, 1, 0, "R8");
    expect_at(b+17, 0, 1, "R8");
    pwm_req = 1; ls_gate_low = 1; sw_low = 1;
    run_to(b+4);  force_off = 1;
    run_to(b+6);  force_off = 0;
    run_to(b+11); pwm_req = 0;
    run_to(b+12); pwm_req = 1;
    run_to(b+15); pwm_req = 0;
    run_to(b+20);

    if (q.size() != 0) begin
      n_tests++;
      n_fail++;
      $display("FAIL scoreboard: %0d expectations left, expected 0", q.size());
    end
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule